// File: doc/BRIEF.md
# Bit-Serial Bus Initiator Port

This block sits between a parallel-side initiator and a bit-serial system bus. The user side offers one transaction at a time: an address, a write byte and a direction flag. The port raises a bus request and waits for a grant. It then shifts the address onto a three-wire serial output (a data bit, a valid qualifier and a mode line), least significant bit first. A write continues with the data byte on the same wires and then waits for an acknowledge. A read collects eight serial bits from the bus and then waits for an acknowledge.

A read target may answer with a split acknowledge instead of data. When that happens, the port withdraws its bus request at once, so other initiators can use the bus. It keeps waiting, with no time limit, for the deferred byte and its acknowledge.

The request interface follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the port is idle. A requester that sees `req_ready` low must hold its request stable and wait. Completion is reported through a one-cycle `done` pulse, the `busy` flag and the `rdata` value. These are plain status outputs with no back-pressure.

Top module: `sbus_init_port`

## Requirements
- R1: While synchronous active-low reset is applied, and in the cycle after it is released, `bus_req`, `so_valid`, `busy` and `done` are 0, `req_ready` is 1 and `rdata` is 0.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. From the next cycle `busy` is 1 and `req_ready` is 0, and both stay so until the cycle of the `done` pulse.
- R3: `bus_req` rises in the cycle after acceptance. `so_valid` stays 0 until `bus_gnt` has been sampled high in that request state. A grant that arrives while the port is idle starts nothing.
- R4: In the cycle after the grant is sampled, the address phase begins and lasts 16 consecutive cycles. In each of these cycles `so_valid` is 1 and `so_data` carries one address bit, bit 0 first. `so_mode` is 1 for a write and 0 for a read throughout the phase.
- R5: On a write, the 8 cycles right after the address phase carry the data byte on `so_data`, bit 0 first, with `so_valid` and `so_mode` at 1.
- R6: `so_valid` is 0 in every cycle outside the address and write-data phases, including while acknowledge or read data is awaited.
- R7: During a read, each cycle with `si_valid` at 1 captures `si_data`. The first captured bit becomes bit 0 of the result. Idle cycles (`si_valid` at 0) may fall between bits, and their `si_data` is ignored.
- R8: `ack_in` completes a write when sampled after the last data bit. It completes a read when sampled after the 8th read bit, or in the same cycle as the 8th bit. The cycle after completion shows `done` at 1 for exactly one cycle, with `busy` at 0.
- R9: If `split_in` is sampled during a read before its first data bit, `bus_req` is 0 from the next cycle until completion. The port keeps waiting for 8 bits and an acknowledge, however long that takes.
- R10: `ack_in` and `split_in` have no effect in any other cycle. This includes the address phase, a read that is still missing bits, and the write acknowledge wait, where `bus_req` stays 1.
- R11: `rdata` changes only while a read collects bits. It holds the last read byte through any idle time and through whole write transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | User request present |
| req_ready | output | 1 | Port can accept a request (idle) |
| req_addr | input | 16 | Transaction address |
| req_wdata | input | 8 | Write byte |
| req_write | input | 1 | 1 = write, 0 = read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| so_data | output | 1 | Serial data out |
| so_valid | output | 1 | Serial out bit qualifier |
| so_mode | output | 1 | Direction line, 1 = write |
| si_data | input | 1 | Serial data in (read data) |
| si_valid | input | 1 | Serial in bit qualifier |
| ack_in | input | 1 | Target acknowledge |
| split_in | input | 1 | Target split acknowledge |

## Verification
Two events can land in the same cycle: the eighth read bit arrives and the target acknowledges. The bench provokes this by raising `ack_in` together with the final `si_valid` bit. It then expects `done` in the very next cycle, with the complete byte already in `rdata`. The same read path is also run with the acknowledge one cycle later, and with idle gaps between bits where stray acknowledge pulses must be ignored. A split acknowledge that arrives together with the wait for the first bit must release `bus_req` in the next cycle.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } sbus_state_e;
endpackage

// File: rtl/sbus_piso.sv
// Parallel-load shifter that presents its LSB first.
module sbus_piso #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         lsb
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= load_val;
    else if (shift) sh <= {1'b0, sh[W-1:1]};
  end

  assign lsb = sh[0];
endmodule

// File: rtl/sbus_sipo.sv
// Collector: each taken bit enters at the top, so the first bit ends at bit 0.
module sbus_sipo #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)    word <= '0;
    else if (take) word <= {bit_in, word[W-1:1]};
  end
endmodule

// File: rtl/sbus_init_port.sv
module sbus_init_port
  import sbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              so_data,
  output logic              so_valid,
  output logic              so_mode,
  input  logic              si_data,
  input  logic              si_valid,
  input  logic              ack_in,
  input  logic              split_in
);
  localparam int CNT_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam logic [CNT_W-1:0] A_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] D_LAST = CNT_W'(DATA_W - 1);

  sbus_state_e      st;
  logic [CNT_W-1:0] cnt;
  logic             wr_q;
  logic             split_q;
  logic             done_q;
  logic             accept;
  logic             a_bit;
  logic             d_bit;
  logic             take_bit;

  assign accept   = req_valid && req_ready;
  assign take_bit = (st == ST_RDAT) && si_valid;

  sbus_piso #(.W(ADDR_W)) i_addr_sh (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(req_addr),
    .shift(st == ST_ADDR), .lsb(a_bit)
  );

  sbus_piso #(.W(DATA_W)) i_data_sh (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(req_wdata),
    .shift(st == ST_WDAT), .lsb(d_bit)
  );

  sbus_sipo #(.W(DATA_W)) i_rd_sh (
    .clk(clk), .rst_n(rst_n), .take(take_bit), .bit_in(si_data), .word(rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      split_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          st      <= ST_REQ;
          wr_q    <= req_write;
          cnt     <= '0;
          split_q <= 1'b0;
        end
        ST_REQ: if (bus_gnt) begin
          st  <= ST_ADDR;
          cnt <= '0;
        end
        ST_ADDR: begin
          if (cnt == A_LAST) begin
            cnt <= '0;
            st  <= wr_q ? ST_WDAT : ST_RDAT;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WDAT: begin
          if (cnt == D_LAST) begin
            cnt <= '0;
            st  <= ST_WACK;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WACK: if (ack_in) begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
        ST_RDAT: begin
          if (cnt == '0 && split_in && !split_q) split_q <= 1'b1;
          if (si_valid) begin
            if (cnt == D_LAST) begin
              cnt <= '0;
              if (ack_in) begin
                st      <= ST_IDLE;
                done_q  <= 1'b1;
                split_q <= 1'b0;
              end else begin
                st <= ST_RACK;
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        ST_RACK: if (ack_in) begin
          st      <= ST_IDLE;
          done_q  <= 1'b1;
          split_q <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign bus_req   = (st != ST_IDLE) && !split_q;
  assign so_valid  = (st == ST_ADDR) || (st == ST_WDAT);
  assign so_data   = (st == ST_ADDR) ? a_bit : ((st == ST_WDAT) ? d_bit : 1'b0);
  assign so_mode   = so_valid && wr_q;

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy); // R2
  AST_TX_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    so_valid |-> bus_req); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_req) && busy) |-> !so_valid); // R9
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> $stable(rdata)); // R11
endmodule

// File: tb/test_sbus_init_port.sv
module test_sbus_init_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_write = 1'b0;
  logic       busy, done;
  logic [7:0] rdata;
  logic       bus_req;
  logic       bus_gnt = 1'b0;
  logic       so_data, so_valid, so_mode;
  logic       si_data = 1'b0;
  logic       si_valid = 1'b0;
  logic       ack_in = 1'b0;
  logic       split_in = 1'b0;

  int total = 0;
  int bad = 0;
  logic [7:0] last_rd = 8'h00;

  always #10 clk = ~clk;

  sbus_init_port i_sbus_init_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .busy(busy), .done(done), .rdata(rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .so_data(so_data), .so_valid(so_valid), .so_mode(so_mode),
    .si_data(si_data), .si_valid(si_valid), .ack_in(ack_in), .split_in(split_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_req == 0 && so_valid == 0, "R1 bus side", {bus_req, so_valid}, 0);
    chk(busy == 0 && done == 0 && req_ready == 1, "R1 user side",
        {busy, done, req_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata == 8'h00 && req_ready == 1 && bus_req == 0, "R1 after release",
        {rdata, req_ready, bus_req}, {8'h00, 2'b10});
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    @(negedge clk);
    chk(so_valid == 0 && busy == 0 && bus_req == 0, "R3 idle grant ignored",
        {so_valid, busy, bus_req}, 0);
  endtask

  task automatic accept_req(input logic [15:0] a, input logic [7:0] d, input bit wr);
    @(negedge clk);
    req_addr = a; req_wdata = d; req_write = wr; req_valid = 1'b1;
    chk(req_ready == 1, "R2 ready when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1 && req_ready == 0, "R2 busy after accept", {busy, req_ready}, 2'b10);
    chk(bus_req == 1, "R3 request raised", bus_req, 1);
  endtask

  task automatic grant_after(input int gd);
    for (int k = 0; k < gd; k++) begin
      chk(so_valid == 0 && bus_req == 1, "R3 no bits before grant", {so_valid, bus_req}, 2'b01);
      @(negedge clk);
    end
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
  endtask

  task automatic get_addr(input logic [15:0] a, input bit mode, input bit noise);
    logic [15:0] got;
    bit vok, mok;
    vok = 1; mok = 1;
    for (int i = 0; i < 16; i++) begin
      if (i > 0) @(negedge clk);
      got[i] = so_data;
      vok &= (so_valid == 1);
      mok &= (so_mode == mode);
      if (noise && i == 3) begin ack_in = 1'b1; split_in = 1'b1; end
      if (noise && i == 4) begin ack_in = 1'b0; split_in = 1'b0; end
    end
    chk(got == a, "R4 address bits", got, a);
    chk(vok && mok, "R4 valid and mode", {vok, mok}, 2'b11);
    if (noise) chk(busy == 1 && done == 0, "R10 ack in address ignored", {busy, done}, 2'b10);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [7:0] d, input int gd);
    logic [7:0] got;
    bit ok;
    ok = 1;
    accept_req(a, d, 1'b1);
    grant_after(gd);
    get_addr(a, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      got[i] = so_data;
      ok &= (so_valid == 1 && so_mode == 1);
    end
    chk(got == d, "R5 write data bits", got, d);
    chk(ok, "R5 valid and mode in data", ok, 1);
    @(negedge clk);
    chk(so_valid == 0 && done == 0, "R6 idle wire while awaiting ack", {so_valid, done}, 0);
    split_in = 1'b1;
    @(negedge clk);
    split_in = 1'b0;
    chk(bus_req == 1 && busy == 1, "R10 split during write ignored", {bus_req, busy}, 2'b11);
    ack_in = 1'b1;
    @(negedge clk);
    ack_in = 1'b0;
    chk(done == 1 && busy == 0, "R8 write done", {done, busy}, 2'b10);
    chk(rdata == last_rd, "R11 write keeps rdata", rdata, last_rd);
    @(negedge clk);
    chk(done == 0 && bus_req == 0, "R8 done single cycle", {done, bus_req}, 0);
  endtask

  task automatic t_read(input logic [15:0] a, input logic [7:0] d, input int gd,
                        input bit split, input bit gaps, input bit coinc);
    accept_req(a, 8'h00, 1'b0);
    grant_after(gd);
    get_addr(a, 1'b0, 1'b0);
    @(negedge clk);
    chk(so_valid == 0 && bus_req == 1, "R6 idle wire in read", {so_valid, bus_req}, 2'b01);
    if (split) begin
      split_in = 1'b1;
      @(negedge clk);
      split_in = 1'b0;
      chk(bus_req == 0 && busy == 1, "R9 request dropped on split", {bus_req, busy}, 2'b01);
      repeat (40) @(negedge clk);
      chk(bus_req == 0 && busy == 1 && done == 0, "R9 waits without limit",
          {bus_req, busy, done}, 3'b010);
    end
    for (int i = 0; i < 8; i++) begin
      if (gaps && (i % 2 == 1)) begin
        si_valid = 1'b0;
        si_data = ~d[i];
        if (i == 3) ack_in = 1'b1;
        @(negedge clk);
        ack_in = 1'b0;
      end
      si_valid = 1'b1;
      si_data = d[i];
      if (i == 7 && coinc) ack_in = 1'b1;
      @(negedge clk);
      si_valid = 1'b0;
      ack_in = 1'b0;
    end
    if (!coinc) begin
      chk(done == 0 && busy == 1, "R10 no done before ack", {done, busy}, 2'b01);
      chk(so_valid == 0, "R6 idle wire awaiting read ack", so_valid, 0);
      ack_in = 1'b1;
      @(negedge clk);
      ack_in = 1'b0;
    end
    chk(done == 1 && busy == 0, coinc ? "R8 ack with last bit" : "R8 read done",
        {done, busy}, 2'b10);
    chk(rdata == d, "R7 read byte", rdata, d);
    last_rd = d;
    repeat (3) @(negedge clk);
    chk(rdata == d && done == 0, "R11 rdata held", {rdata, done}, {d, 1'b0});
  endtask

  initial begin
    t_reset();
    t_write(16'h9A5C, 8'h3C, 0);
    t_read(16'h0123, 8'hA7, 2, 1'b0, 1'b0, 1'b0);
    t_write(16'h8001, 8'hFF, 3);
    t_read(16'hFFFE, 8'h5B, 1, 1'b1, 1'b1, 1'b0);
    t_read(16'h4000, 8'h81, 0, 1'b0, 1'b1, 1'b1);
    t_read(16'h7FFF, 8'h6E, 0, 1'b1, 1'b0, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule